// File: doc/BRIEF.md
# Stereo I2S Serial Audio Transmitter

This block places pairs of 16-bit PCM samples onto a single I2S data line. The bit clock and the word-select line come in as ordinary inputs. The block runs on a faster system clock and samples both lines through synchronizer flops to find their edges. A change of word select is judged only at a detected falling edge of the bit clock, and the old and new levels are compared inside that same qualified step. Because of this, every sample boundary is seen, and the line never gets stuck shifting out zeros. Each slot starts one bit clock after word select toggles and sends the sample most significant bit first. Zeros fill the rest of the 32-bit slot.

A divider is included alongside the transmitter. It makes a bit clock of `DIV` system clocks and a word select with 32 bit clocks per channel, which is 64 per stereo frame. Its two outputs can be wired back to the clock inputs, or the transmitter can follow any external pair of clocks. With a 40 MHz system clock and `DIV` = 8, the bit clock is 5 MHz and the frame rate is about 78 kHz. That bit clock lies inside the 2.048 to 6.144 MHz window the downstream amplifier accepts.

The serializer is a state machine with three states:
- `ST_WAIT_SYNC`: after reset, the line is held low.
- `ST_ARMED`: a new slot word has been loaded, and the block waits out the one-bit delay.
- `ST_SEND`: the block is shifting bits out.

Its transitions are:
- `WAIT_SYNC→ARMED` on the first left edge.
- `ARMED→SEND` on the next bit-clock fall.
- `ARMED/SEND→ARMED` on any word-select change seen at a bit-clock fall.

Top module: `sat_top`

## Requirements
- R1: While reset is held, and after reset until the first word-select change to low, `sdata` is 0. While reset is held, `gen_bclk` and `gen_ws` are 0.
- R2: Word select is compared only at a detected falling edge of `bclk_in`. Every change found there starts a new slot, and no slot boundary is skipped in any frame.
- R3: The first bit of a slot, its MSB, appears at the first `bclk_in` falling edge after the falling edge at which word select changed.
- R4: Each sample is sent MSB first as 16 bits. The remaining bits of the slot are 0, including the bit driven at the falling edge where word select next changes.
- R5: A slot that begins with `ws_in` = 0 carries the left sample. A slot that begins with `ws_in` = 1 carries the right sample.
- R6: `sdata` changes only after a detected falling edge of `bclk_in`, so it is stable across each rising edge.
- R7: `left_in` and `right_in` are both captured at the change of word select to low. Input changes at any other time do not alter the frame already captured.
- R8: `gen_bclk` has a period of `DIV` system clocks, high for `DIV`/2 of them. `gen_ws` changes only together with a falling edge of `gen_bclk`, and stays at each level for 32 bit clocks.
- R9: The transmitter follows externally supplied clocks of another rate and slot length. With 24-bit-clock slots, each sample is still sent in full and is followed by 8 zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Bit clock that times the serializer |
| ws_in | input | 1 | Word select: 0 left, 1 right |
| left_in | input | 16 | Left-channel PCM sample |
| right_in | input | 16 | Right-channel PCM sample |
| sdata | output | 1 | Serial audio data, MSB first |
| gen_bclk | output | 1 | Bit clock from the built-in divider |
| gen_ws | output | 1 | Word select from the built-in divider |

## Verification
The assertions assume several things about the inputs:
- `bclk_in` stays high and low for more system clocks than the synchronizer depth plus one.
- `ws_in` moves only with a falling edge of `bclk_in`.
- Both clock inputs are free of glitches once they pass the synchronizer.

The stimulus keeps to these assumptions in both phases. The first phase wires the divider outputs back to the inputs. The second phase drives a 12-cycle bit clock whose word select toggles only at falling edges, every 24 bit clocks. In both phases, new sample pairs change only well after the capture edge.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_SYNC = 2'd0,
        ST_ARMED     = 2'd1,
        ST_SEND      = 2'd2
    } sat_state_e;
endpackage

// File: rtl/sat_clkdiv.sv
module sat_clkdiv #(
    parameter int DIV    = 8,
    parameter int SLOT_W = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic bclk,
    output logic ws
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int SW   = $clog2(2 * SLOT_W);

    logic [CW-1:0] div_cnt;
    logic [SW-1:0] bit_cnt;
    logic [SW-1:0] bit_nxt;

    assign bit_nxt = bit_cnt + SW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bit_cnt <= '0;
            bclk    <= 1'b0;
            ws      <= 1'b0;
        end else begin
            div_cnt <= (div_cnt == CW'(DIV - 1)) ? '0 : div_cnt + CW'(1);
            if (div_cnt == CW'(HALF - 1)) begin
                bclk <= 1'b1;
            end
            if (div_cnt == CW'(DIV - 1)) begin
                bclk    <= 1'b0;
                bit_cnt <= bit_nxt;
                ws      <= bit_nxt[SW-1];
            end
        end
    end

    AST_WS_ON_BCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> $fell(bclk)); // R8
endmodule

// File: rtl/sat_sync.sv
module sat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sat_serializer.sv
module sat_serializer
    import sat_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_s,
    input  logic                ws_s,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                sdata
);
    localparam int PAD = SLOT_W - SAMPLE_W;

    sat_state_e state, state_nxt;

    logic                bclk_prev;
    logic                ws_last;
    logic [SAMPLE_W-1:0] hold_r;
    logic [SLOT_W-1:0]   shreg;
    logic                sdata_r;

    logic bclk_fall;
    logic ws_edge;
    logic left_edge;

    function automatic logic [SLOT_W-1:0] place(input logic [SAMPLE_W-1:0] s);
        return SLOT_W'(s) << PAD;
    endfunction

    // Sync level is read and compared only inside the qualified fall step.
    assign bclk_fall = bclk_prev & ~bclk_s;
    assign ws_edge   = bclk_fall & (ws_s != ws_last);
    assign left_edge = ws_edge & ~ws_s;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_SYNC: if (left_edge)      state_nxt = ST_ARMED;
            ST_ARMED: begin
                if (ws_edge)                  state_nxt = ST_ARMED;
                else if (bclk_fall)           state_nxt = ST_SEND;
            end
            ST_SEND:      if (ws_edge)        state_nxt = ST_ARMED;
            default:                          state_nxt = ST_WAIT_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_WAIT_SYNC;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_prev <= 1'b0;
            ws_last   <= 1'b0;
            hold_r    <= '0;
            shreg     <= '0;
            sdata_r   <= 1'b0;
        end else begin
            bclk_prev <= bclk_s;
            if (bclk_fall) begin
                ws_last <= ws_s;
            end
            if (left_edge) begin
                hold_r <= right_in;
            end
            if (bclk_fall) begin
                if (ws_edge && (state != ST_WAIT_SYNC || !ws_s)) begin
                    sdata_r <= (state == ST_SEND) ? shreg[SLOT_W-1] : 1'b0;
                    shreg   <= ws_s ? place(hold_r) : place(left_in);
                end else if (state != ST_WAIT_SYNC) begin
                    sdata_r <= shreg[SLOT_W-1];
                    shreg   <= shreg << 1;
                end else begin
                    sdata_r <= 1'b0;
                end
            end
        end
    end

    assign sdata = sdata_r;

    AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_SYNC) |=> (sdata == 1'b0)); // R1
    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_edge && state != ST_WAIT_SYNC) |=> (state == ST_ARMED)); // R2
    AST_MSB_NEXT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && bclk_fall && !ws_edge) |=> (state == ST_SEND)); // R3
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> $stable(sdata)); // R6
    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !left_edge |=> $stable(hold_r)); // R7
endmodule

// File: rtl/sat_top.sv
module sat_top #(
    parameter int DIV         = 8,
    parameter int SLOT_W      = 32,
    parameter int SAMPLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                ws_in,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                sdata,
    output logic                gen_bclk,
    output logic                gen_ws
);
    logic bclk_s;
    logic ws_s;

    sat_clkdiv #(.DIV(DIV), .SLOT_W(SLOT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .bclk(gen_bclk), .ws(gen_ws)
    );

    sat_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (
        .clk(clk), .rst_n(rst_n), .d(bclk_in), .q(bclk_s)
    );

    sat_sync #(.STAGES(SYNC_STAGES)) u_sync_ws (
        .clk(clk), .rst_n(rst_n), .d(ws_in), .q(ws_s)
    );

    sat_serializer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .bclk_s(bclk_s), .ws_s(ws_s),
        .left_in(left_in), .right_in(right_in), .sdata(sdata)
    );
endmodule

// File: tb/sat_top_test.sv
module sat_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic        tb_bclk = 1'b0;
    logic        tb_ws = 1'b0;
    logic [15:0] left_in = '0;
    logic [15:0] right_in = '0;
    logic        sdata, gen_bclk, gen_ws;
    logic        bclk_in, ws_in;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    logic [16:0] exp_q[$];

    always #5 clk = ~clk;

    assign bclk_in = ext_mode ? tb_bclk : gen_bclk;
    assign ws_in   = ext_mode ? tb_ws   : gen_ws;

    sat_top uut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .ws_in(ws_in),
        .left_in(left_in), .right_in(right_in), .sdata(sdata),
        .gen_bclk(gen_bclk), .gen_ws(gen_ws)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // External clock source: 12-cycle bit clock, word select every 24 falls
    int ext_ph = 0;
    int ext_falls = 0;
    always @(posedge clk) begin
        if (ext_mode && rst_n) begin
            ext_ph <= (ext_ph == 11) ? 0 : ext_ph + 1;
            if (ext_ph == 5) tb_bclk <= 1'b1;
            if (ext_ph == 11) begin
                tb_bclk <= 1'b0;
                if (ext_falls == 23) begin
                    ext_falls <= 0;
                    tb_ws <= ~tb_ws;
                end else begin
                    ext_falls <= ext_falls + 1;
                end
            end
        end
    end

    // Divider timing checks (R8)
    int  dv_cnt = 0, dv_hi = 0, dv_falls = 0, dv_checks = 0;
    logic dv_pb = 1'b0, dv_pw = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            dv_cnt = 0; dv_hi = 0; dv_falls = 0; dv_pb = 1'b0; dv_pw = 1'b0;
        end else begin
            dv_cnt++;
            if (gen_bclk) dv_hi++;
            if (gen_ws != dv_pw && dv_checks < 8)
                check(dv_pb && !gen_bclk, "R8 ws moves with bclk fall", gen_bclk, 0);
            if (dv_pb && !gen_bclk) begin
                if (dv_checks < 8 && dv_falls > 1) begin
                    check(dv_cnt == 8, "R8 bclk period", dv_cnt, 8);
                    check(dv_hi == 4, "R8 bclk high time", dv_hi, 4);
                end
                dv_cnt = 0; dv_hi = 0;
                dv_falls++;
            end
            if (gen_ws != dv_pw) begin
                if (dv_checks < 8 && dv_falls > 40)
                    check(dv_falls == 32, "R8 ws half period", dv_falls, 32);
                if (dv_falls > 40 || dv_falls == 32) dv_checks++;
                dv_falls = 0;
            end
            dv_pb = gen_bclk; dv_pw = gen_ws;
        end
    end

    // Monitor: decode slots from the serial line and compare with the scoreboard
    logic m_pb = 1'b0, m_lastws = 1'b0, p_ws = 1'b0;
    bit   m_act = 1'b0, p_valid = 1'b0, p_chg = 1'b0, pad_ok = 1'b1, slot_done = 1'b1;
    int   p_wait = 0, idx = 0;
    logic [15:0] word = '0;
    logic cur_ws = 1'b0;
    always @(negedge clk) begin
        if (!rst_n || !mon_en) begin
            m_pb = 1'b0; m_lastws = 1'b0; m_act = 1'b0; p_valid = 1'b0;
            slot_done = 1'b1; pad_ok = 1'b1;
        end else begin
            if (m_pb && !bclk_in) begin
                p_valid = 1'b1; p_wait = 5;
                p_chg = (ws_in != m_lastws);
                p_ws = ws_in;
                m_lastws = ws_in;
            end
            m_pb = bclk_in;
            if (p_valid) begin
                p_wait--;
                if (p_wait == 0) begin
                    p_valid = 1'b0;
                    if (p_chg && !p_ws && !m_act) begin
                        m_act = 1'b1;
                        check(sdata == 1'b0, "R1 line low before first left slot", sdata, 0);
                        cur_ws = 1'b0; idx = 0; word = '0; pad_ok = 1'b1; slot_done = 1'b0;
                    end else if (m_act) begin
                        if (p_chg) begin
                            check(slot_done, "R2 slot boundary not skipped", slot_done, 1);
                            check(pad_ok && sdata == 1'b0, "R4 pad bits zero", {pad_ok, sdata}, 2'b10);
                            cur_ws = p_ws; idx = 0; word = '0; pad_ok = 1'b1; slot_done = 1'b0;
                        end else begin
                            idx++;
                            if (idx <= 16) begin
                                word = {word[14:0], sdata};
                                if (idx == 16) begin
                                    slot_done = 1'b1;
                                    if (exp_q.size() == 0) begin
                                        check(1'b0, "R7 unexpected slot", word, 0);
                                    end else begin
                                        logic [16:0] e;
                                        e = exp_q.pop_front();
                                        check(e[16] == cur_ws, "R5 channel order", cur_ws, e[16]);
                                        check(word == e[15:0], "R3 R4 R7 sample bits MSB first",
                                              word, e[15:0]);
                                    end
                                end
                            end else if (sdata != 1'b0) begin
                                pad_ok = 1'b0;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic wait_ws_rise();
        logic p;
        p = ws_in;
        forever begin
            @(negedge clk);
            if (!p && ws_in) break;
            p = ws_in;
        end
    endtask

    task automatic wait_ws_fall();
        logic p;
        p = ws_in;
        forever begin
            @(negedge clk);
            if (p && !ws_in) break;
            p = ws_in;
        end
    endtask

    // Driver: new pair right after the right-slot start, junk mid left slot
    task automatic run_phase(input int n, input logic [15:0] seed);
        for (int i = 0; i < n; i++) begin
            logic [15:0] l, r;
            case (i)
                0: begin l = 16'h8000; r = 16'h0001; end
                1: begin l = 16'hFFFF; r = 16'h0000; end
                default: begin
                    l = seed ^ 16'(i * 16'h1357);
                    r = {l[7:0], ~l[15:8]};
                end
            endcase
            wait_ws_rise();
            if (i == 0 && !ext_mode)
                check(sdata == 1'b0, "R1 quiet until first left edge", sdata, 0);
            left_in = l; right_in = r;
            exp_q.push_back({1'b0, l});
            exp_q.push_back({1'b1, r});
            wait_ws_fall();
            repeat (6) @(negedge clk);
            left_in = ~l; right_in = 16'hDEAD ^ r;   // R7: must not affect this frame
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(sdata == 1'b0, "R1 sdata in reset", sdata, 0);
        check(gen_bclk == 1'b0, "R1 gen_bclk in reset", gen_bclk, 0);
        check(gen_ws == 1'b0, "R1 gen_ws in reset", gen_ws, 0);
        mon_en = 1'b1;
        rst_n = 1'b1;
        run_phase(6, 16'hA5C3);

        // External clocks, 24-bit-clock slots (R9)
        @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        ext_mode = 1'b1;
        tb_bclk = 1'b0; tb_ws = 1'b0; ext_ph = 0; ext_falls = 0;
        repeat (4) @(negedge clk);
        check(sdata == 1'b0, "R1 sdata in second reset", sdata, 0);
        mon_en = 1'b1;
        rst_n = 1'b1;
        run_phase(5, 16'h3C5A);
        check(exp_q.size() == 0, "R9 all external slots decoded", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule